// File: doc/BRIEF.md
# Indexed Load Address Unit

This block carries out word loads for a small 32-bit core. Decode hands it one request at a time. The request holds an addressing variant, the base register value, an offset register value, an immediate offset field, a condition-pass flag, and the destination and base register indices. The unit forms the byte address and issues one word read on a valid/ready memory request channel. It then waits for the memory response.

On a good response the unit returns the loaded word on a destination write port. For write-back variants it also returns the updated base on a second, independent write port in the same cycle. If the memory reports a fault, the unit raises a one-cycle fault exception and writes nothing. The kernel can then repair the mapping and replay the load, because no register has changed.

The unit holds at most one load in flight. It reports `busy` from the cycle after acceptance until the cycle in which the result appears. While `busy` is high, new requests are ignored.

Top module: `ldx_unit`

## Requirements
- R1: The offset is chosen by variant bit 2. When that bit is 1, the offset register value is used as a full 32-bit value, and all sums wrap modulo 2^32. When that bit is 0, the offset is the 11-bit immediate shifted left by 2 (range 0 to 8188) if `req_imm_given` is 1, and 4 otherwise.
- R2: Variant bits [1:0] = 0 (plain pre-index) reads at base + offset and asserts no base write. Code 3 behaves the same way.
- R3: Variant bits [1:0] = 1 (pre-index with write-back) reads at base + offset and writes that same sum to the base register.
- R4: Variant bits [1:0] = 2 (post-index with write-back) reads at the unmodified base and writes base + offset to the base register.
- R5: A request accepted with `req_cond_pass` = 0 has no effect. It issues no memory read, asserts no write strobe and leaves `busy` low.
- R6: A request is accepted when `req_valid` is 1 and `busy` is 0. From the next cycle `mem_req_valid` is high and `busy` is high. `mem_addr` stays stable until `mem_req_ready` is seen. Only one read is issued per load, and requests arriving while `busy` is high are ignored.
- R7: Results are due in the cycle after the cycle in which `mem_rsp_valid` is sampled high. `dst_we` and, for write-back variants, `src_we` are asserted together for exactly one cycle. `busy` is low in that same cycle.
- R8: A response with `mem_rsp_fault` = 1 produces a one-cycle `fault_exc` pulse. In that case neither `dst_we` nor `src_we` is asserted.
- R9: On a write-back variant whose destination index equals its base index, only the destination write occurs, and it carries the loaded word.
- R10: After reset, `busy`, `mem_req_valid`, `dst_we`, `src_we` and `fault_exc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_variant | input | 3 | Bit 2: register offset; bits [1:0]: 0 pre, 1 pre write-back, 2 post write-back |
| req_base | input | 32 | Base register value |
| req_roff | input | 32 | Offset register value |
| req_imm | input | 11 | Immediate offset in words |
| req_imm_given | input | 1 | Immediate present (else offset 4) |
| req_cond_pass | input | 1 | Condition evaluated true |
| req_dst | input | 5 | Destination register index |
| req_src | input | 5 | Base register index |
| busy | output | 1 | Load in flight; requests ignored |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_fault | input | 1 | Access failed |
| mem_rsp_data | input | 32 | Read word |
| dst_we | output | 1 | Destination write strobe |
| dst_idx | output | 5 | Destination index |
| dst_data | output | 32 | Loaded word |
| src_we | output | 1 | Base write-back strobe |
| src_idx | output | 5 | Base index |
| src_data | output | 32 | Updated base |
| fault_exc | output | 1 | Memory-fault exception pulse |

## Verification
Each response has a fixed latency through the unit, and the bench checks every result at that cycle. The bench drives inputs and samples outputs at falling edges. After the accepting edge, `mem_req_valid`, `mem_addr` and `busy` are checked at the very next falling edge. Once `mem_req_ready` is seen, `mem_req_valid` must be low at the next falling edge. The write strobes and `fault_exc` must appear at the falling edge right after the edge that samples `mem_rsp_valid`, and must be gone one falling edge later. Ready and response delays vary between scenarios, so a result that arrives early or late fails a strobe check.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  typedef enum logic [1:0] {
    IDX_PRE     = 2'd0,
    IDX_PRE_WB  = 2'd1,
    IDX_POST_WB = 2'd2,
    IDX_RSVD    = 2'd3
  } idx_mode_e;

  typedef struct packed {
    logic      reg_off;
    idx_mode_e mode;
  } ldx_variant_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ldx_state_e;
endpackage

// File: rtl/ldx_agen.sv
module ldx_agen
  import ldx_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IMMW      = 11,
  parameter int IMM_SHIFT = 2,
  parameter int DEF_OFF   = 4
) (
  input  ldx_variant_t    variant,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] roff,
  input  logic [IMMW-1:0] imm,
  input  logic            imm_given,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] new_base,
  output logic            base_wb
);
  localparam int SCALED_W = IMMW + IMM_SHIFT;

  logic [XLEN-1:0] off;
  logic [XLEN-1:0] sum;

  always_comb begin
    off = '0;
    if (variant.reg_off) begin
      off = roff;
    end else if (imm_given) begin
      off[SCALED_W-1:0] = {imm, {IMM_SHIFT{1'b0}}};
    end else begin
      off = XLEN'(DEF_OFF);
    end
    sum      = base + off;
    new_base = sum;
    case (variant.mode)
      IDX_PRE_WB:  begin addr = sum;  base_wb = 1'b1; end
      IDX_POST_WB: begin addr = base; base_wb = 1'b1; end
      default:     begin addr = sum;  base_wb = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ldx_ctrl.sv
module ldx_ctrl
  import ldx_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_cond_pass,
  input  logic [XLEN-1:0] addr_in,
  input  logic [XLEN-1:0] nbase_in,
  input  logic            wb_in,
  input  logic [RIW-1:0]  dst_in,
  input  logic [RIW-1:0]  src_in,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  output logic            busy,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_addr,
  output logic            take,
  output logic [XLEN-1:0] held_nbase,
  output logic            held_wb,
  output logic [RIW-1:0]  held_dst,
  output logic [RIW-1:0]  held_src
);
  ldx_state_e state;
  logic [XLEN-1:0] held_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      held_addr  <= '0;
      held_nbase <= '0;
      held_wb    <= 1'b0;
      held_dst   <= '0;
      held_src   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid && req_cond_pass) begin
          state      <= ST_ISSUE;
          held_addr  <= addr_in;
          held_nbase <= nbase_in;
          held_wb    <= wb_in;
          held_dst   <= dst_in;
          held_src   <= src_in;
        end
        ST_ISSUE: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT:  if (mem_rsp_valid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_addr      = held_addr;
  assign take          = (state == ST_WAIT) && mem_rsp_valid;

  a_r6_addr_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
  a_r6_req_while_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);
  a_r6_single_issue: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
  a_r5_cond_fail_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && !req_cond_pass) |=> !busy);
endmodule

// File: rtl/ldx_retire.sv
module ldx_retire #(
  parameter int XLEN = 32,
  parameter int RIW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            rsp_fault,
  input  logic [XLEN-1:0] rsp_data,
  input  logic [XLEN-1:0] held_nbase,
  input  logic            held_wb,
  input  logic [RIW-1:0]  held_dst,
  input  logic [RIW-1:0]  held_src,
  output logic            dst_we,
  output logic [RIW-1:0]  dst_idx,
  output logic [XLEN-1:0] dst_data,
  output logic            src_we,
  output logic [RIW-1:0]  src_idx,
  output logic [XLEN-1:0] src_data,
  output logic            fault_exc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dst_we    <= 1'b0;
      src_we    <= 1'b0;
      fault_exc <= 1'b0;
      dst_idx   <= '0;
      dst_data  <= '0;
      src_idx   <= '0;
      src_data  <= '0;
    end else begin
      dst_we    <= take && !rsp_fault;
      src_we    <= take && !rsp_fault && held_wb && (held_src != held_dst);
      fault_exc <= take && rsp_fault;
      if (take) begin
        dst_idx  <= held_dst;
        dst_data <= rsp_data;
        src_idx  <= held_src;
        src_data <= held_nbase;
      end
    end
  end

  a_r8_fault_no_write: assert property (@(posedge clk) disable iff (rst)
    fault_exc |-> (!dst_we && !src_we));
  a_r7_pair_together: assert property (@(posedge clk) disable iff (rst)
    src_we |-> dst_we);
  a_r9_distinct_idx: assert property (@(posedge clk) disable iff (rst)
    src_we |-> (src_idx != dst_idx));
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dst_we |=> !dst_we);
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
  import ldx_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int RIW       = 5,
  parameter int IMMW      = 11,
  parameter int IMM_SHIFT = 2,
  parameter int DEF_OFF   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_variant,
  input  logic [XLEN-1:0] req_base,
  input  logic [XLEN-1:0] req_roff,
  input  logic [IMMW-1:0] req_imm,
  input  logic            req_imm_given,
  input  logic            req_cond_pass,
  input  logic [RIW-1:0]  req_dst,
  input  logic [RIW-1:0]  req_src,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_fault,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            dst_we,
  output logic [RIW-1:0]  dst_idx,
  output logic [XLEN-1:0] dst_data,
  output logic            src_we,
  output logic [RIW-1:0]  src_idx,
  output logic [XLEN-1:0] src_data,
  output logic            fault_exc
);
  ldx_variant_t    var_s;
  logic [XLEN-1:0] ag_addr, ag_nbase, h_nbase;
  logic            ag_wb, h_wb, take;
  logic [RIW-1:0]  h_dst, h_src;

  assign var_s = ldx_variant_t'(req_variant);

  ldx_agen #(.XLEN(XLEN), .IMMW(IMMW), .IMM_SHIFT(IMM_SHIFT), .DEF_OFF(DEF_OFF)) u_agen (
    .variant(var_s), .base(req_base), .roff(req_roff), .imm(req_imm),
    .imm_given(req_imm_given), .addr(ag_addr), .new_base(ag_nbase), .base_wb(ag_wb)
  );

  ldx_ctrl #(.XLEN(XLEN), .RIW(RIW)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cond_pass(req_cond_pass),
    .addr_in(ag_addr), .nbase_in(ag_nbase), .wb_in(ag_wb),
    .dst_in(req_dst), .src_in(req_src),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_addr(mem_addr), .take(take),
    .held_nbase(h_nbase), .held_wb(h_wb), .held_dst(h_dst), .held_src(h_src)
  );

  ldx_retire #(.XLEN(XLEN), .RIW(RIW)) u_retire (
    .clk(clk), .rst(rst), .take(take), .rsp_fault(mem_rsp_fault), .rsp_data(mem_rsp_data),
    .held_nbase(h_nbase), .held_wb(h_wb), .held_dst(h_dst), .held_src(h_src),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .src_we(src_we), .src_idx(src_idx), .src_data(src_data), .fault_exc(fault_exc)
  );
endmodule

// File: tb/ldx_unit_bench.sv
module ldx_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_variant = '0;
  logic [31:0] req_base = '0, req_roff = '0;
  logic [10:0] req_imm = '0;
  logic        req_imm_given = 1'b0, req_cond_pass = 1'b0;
  logic [4:0]  req_dst = '0, req_src = '0;
  logic        busy, mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_fault = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        dst_we, src_we, fault_exc;
  logic [4:0]  dst_idx, src_idx;
  logic [31:0] dst_data, src_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ldx_unit u_ldx_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_variant(req_variant),
    .req_base(req_base), .req_roff(req_roff), .req_imm(req_imm),
    .req_imm_given(req_imm_given), .req_cond_pass(req_cond_pass),
    .req_dst(req_dst), .req_src(req_src), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_fault(mem_rsp_fault), .mem_rsp_data(mem_rsp_data),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .src_we(src_we), .src_idx(src_idx), .src_data(src_data), .fault_exc(fault_exc)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One complete load: drives the request, plays the memory, checks every result.
  task automatic run_load(input string tag, input logic [2:0] vr, input logic [31:0] base,
                          input logic [31:0] roff, input logic [10:0] imm, input logic given,
                          input logic cond, input logic [4:0] dst, input logic [4:0] src,
                          input logic flt, input int rdly, input int sdly, input bit probe);
    logic [31:0] off, eaddr, enb, edata;
    logic wb, exp_src;
    off   = vr[2] ? roff : (given ? {19'd0, imm, 2'b00} : 32'd4);
    eaddr = (vr[1:0] == 2'd2) ? base : base + off;
    enb   = base + off;
    wb    = (vr[1:0] == 2'd1) || (vr[1:0] == 2'd2);
    edata = eaddr ^ 32'hA5A5_0000;
    exp_src = !flt && wb && (src != dst);
    @(negedge clk);
    req_variant = vr; req_base = base; req_roff = roff; req_imm = imm;
    req_imm_given = given; req_cond_pass = cond; req_dst = dst; req_src = src;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!cond) begin
      chk(tag, "busy after skipped load", {31'd0, busy}, 32'd0);
      for (int i = 0; i < 3; i++) begin
        chk(tag, "no mem read", {31'd0, mem_req_valid}, 32'd0);
        chk(tag, "no writes", {30'd0, dst_we, src_we}, 32'd0);
        @(negedge clk);
      end
      return;
    end
    chk("R6", "busy after accept", {31'd0, busy}, 32'd1);
    for (int i = 0; i < rdly; i++) begin
      chk("R6", "req held", {31'd0, mem_req_valid}, 32'd1);
      chk("R6", "addr held", mem_addr, eaddr);
      if (probe) begin
        req_valid = 1'b1; req_base = base + 32'h100; req_cond_pass = 1'b1;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(tag, "mem_req_valid", {31'd0, mem_req_valid}, 32'd1);
    chk(tag, "mem_addr", mem_addr, eaddr);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R6", "single read", {31'd0, mem_req_valid}, 32'd0);
    for (int i = 0; i < sdly; i++) begin
      chk("R7", "no early result", {29'd0, dst_we, src_we, fault_exc}, 32'd0);
      chk("R6", "busy waiting", {31'd0, busy}, 32'd1);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1; mem_rsp_fault = flt; mem_rsp_data = edata;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_fault = 1'b0; mem_rsp_data = '0;
    chk(flt ? "R8" : "R7", "dst_we", {31'd0, dst_we}, {31'd0, !flt});
    chk(flt ? "R8" : tag, "src_we", {31'd0, src_we}, {31'd0, exp_src});
    chk("R8", "fault_exc", {31'd0, fault_exc}, {31'd0, flt});
    chk("R7", "busy at result", {31'd0, busy}, 32'd0);
    if (!flt) begin
      chk("R7", "dst_idx", {27'd0, dst_idx}, {27'd0, dst});
      chk("R7", "dst_data", dst_data, edata);
    end
    if (exp_src) begin
      chk(tag, "src_idx", {27'd0, src_idx}, {27'd0, src});
      chk(tag, "src_data", src_data, enb);
    end
    @(negedge clk);
    chk("R7", "strobes one cycle", {29'd0, dst_we, src_we, fault_exc}, 32'd0);
    chk("R6", "no extra read", {31'd0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10", "reset outputs", {27'd0, busy, mem_req_valid, dst_we, src_we, fault_exc}, 32'd0);
  endtask

  task automatic t_imm_pre;
    run_load("R2", 3'b000, 32'h0000_1000, 32'h0, 11'd2047, 1'b1, 1'b1, 5'd1, 5'd2, 1'b0, 0, 0, 1'b0);
    run_load("R1", 3'b000, 32'h0000_2000, 32'h0, 11'd9,    1'b0, 1'b1, 5'd3, 5'd4, 1'b0, 1, 2, 1'b0);
    run_load("R2", 3'b011, 32'h0000_3000, 32'h0, 11'd5,    1'b1, 1'b1, 5'd3, 5'd4, 1'b0, 0, 1, 1'b0);
  endtask

  task automatic t_imm_wb;
    run_load("R3", 3'b001, 32'h0000_4000, 32'h0, 11'd2,  1'b1, 1'b1, 5'd5, 5'd6, 1'b0, 2, 0, 1'b0);
    run_load("R4", 3'b010, 32'h0000_5000, 32'h0, 11'd0,  1'b0, 1'b1, 5'd7, 5'd8, 1'b0, 0, 3, 1'b0);
  endtask

  task automatic t_reg_modes;
    run_load("R1", 3'b100, 32'hFFFF_FFF0, 32'h0000_0020, 11'd0, 1'b0, 1'b1, 5'd9,  5'd10, 1'b0, 0, 0, 1'b0);
    run_load("R3", 3'b101, 32'h1234_0000, 32'h0000_0ABC, 11'd0, 1'b0, 1'b1, 5'd11, 5'd12, 1'b0, 1, 1, 1'b0);
    run_load("R4", 3'b110, 32'hFFFF_FFFC, 32'h0000_0008, 11'd0, 1'b0, 1'b1, 5'd13, 5'd14, 1'b0, 0, 2, 1'b0);
  endtask

  task automatic t_cond_skip;
    run_load("R5", 3'b101, 32'h0000_6000, 32'h10, 11'd0, 1'b0, 1'b0, 5'd1, 5'd2, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic t_fault;
    run_load("R8", 3'b001, 32'h0000_7000, 32'h0, 11'd3, 1'b1, 1'b1, 5'd15, 5'd16, 1'b1, 1, 1, 1'b0);
    run_load("R8", 3'b110, 32'h0000_8000, 32'h4, 11'd0, 1'b0, 1'b1, 5'd17, 5'd18, 1'b1, 0, 0, 1'b0);
  endtask

  task automatic t_same_idx;
    run_load("R9", 3'b010, 32'h0000_9000, 32'h0, 11'd1, 1'b1, 1'b1, 5'd20, 5'd20, 1'b0, 0, 1, 1'b0);
    run_load("R9", 3'b101, 32'h0000_A000, 32'h8, 11'd0, 1'b0, 1'b1, 5'd21, 5'd21, 1'b0, 1, 0, 1'b0);
  endtask

  task automatic t_busy_ignore;
    run_load("R6", 3'b001, 32'h0000_B000, 32'h0, 11'd4, 1'b1, 1'b1, 5'd22, 5'd23, 1'b0, 3, 2, 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_imm_pre();
    t_imm_wb();
    t_reg_modes();
    t_cond_skip();
    t_fault();
    t_same_idx();
    t_busy_ignore();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule